// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch is taken by running two component predictors side by side and letting a per-address selector decide which one to trust. The global component is a table of 2-bit counters indexed by a shift register holding the outcomes of the most recent branches. The local component is two-level. A per-branch history table, indexed by low PC bits, yields a pattern of that branch's recent outcomes. The pattern then indexes a table of wider saturating counters. The selector is a table of 2-bit counters, indexed by low PC bits.

A lookup presents a PC and receives the final prediction in the same cycle. It also receives both component predictions, the selector decision and the two history values used, which together form the snapshot. When the branch resolves, the front end returns the PC, the outcome and that snapshot on the update port. The block then trains both component counters at the snapshot indices, nudges the selector, and shifts the outcome into the global history and into the branch's local history entry. The table sizes are parameters. The defaults are kept small; production sizing uses 12 global history bits, a 1K-entry local history table, 10-bit local patterns and a 4K-entry selector.

Top module: `tournament_predictor`

## Requirements
- R1: After reset every 2-bit counter holds 01, every local counter holds 011 (for LC_W=3, generally 0 followed by ones), and all histories are zero. A lookup right after reset therefore predicts not-taken, selects the local side, and reports zero histories.
- R2: The selector counter at lk_pc[CH_IDX_W-1:0] picks the global prediction when its value is 2 or 3, and the local prediction when it is 0 or 1. lk_taken equals the picked prediction.
- R3: On each update, the global counter at index up_ghist counts up by one on taken and down by one on not-taken, saturating at 0 and 3. Its MSB is the global prediction.
- R4: On each update, the LC_W-bit local counter at index up_lhist counts up on taken and down on not-taken, saturating at 0 and 2^LC_W-1. Its MSB is the local prediction.
- R5: Each update shifts the global history left by one, with up_taken entering bit 0. Without an update the global history holds its value.
- R6: Each update shifts up_taken into bit 0 of the local history entry at up_pc[LH_IDX_W-1:0]. PCs sharing those low bits share an entry.
- R7: Component training uses the snapshot indices carried on the update port, not the current histories. A component counts as correct when its counter MSB, read at its snapshot index before training, equals up_taken.
- R8: The selector entry at up_pc[CH_IDX_W-1:0] counts up (saturating at 3) when only the global side was correct. It counts down (saturating at 0) when only the local side was correct. It is unchanged when both sides were right or both were wrong.
- R9: An update in the same cycle as a lookup is applied first. The lookup sees the shifted global history, the updated local history entry and the trained counters wherever the indices coincide.
- R10: lk_ghist and lk_lhist report the global history and local pattern that produced the prediction. lk_glob_taken, lk_loc_taken and lk_use_global report the two component predictions and the selector decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | PC of the branch being looked up |
| lk_taken | output | 1 | Final direction prediction |
| lk_use_global | output | 1 | Selector chose the global side |
| lk_glob_taken | output | 1 | Global component prediction |
| lk_loc_taken | output | 1 | Local component prediction |
| lk_ghist | output | GH_W | Global history used by this lookup |
| lk_lhist | output | LP_W | Local pattern used by this lookup |
| up_valid | input | 1 | Update strobe |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Resolved outcome |
| up_ghist | input | GH_W | Global history snapshot from the lookup |
| up_lhist | input | LP_W | Local pattern snapshot from the lookup |

## Verification
The assertions assume that up_valid and every update field are defined (never X) while reset is released. They also assume reset stays low for at least two clock edges, so that the step and hold properties only ever compare trained entries. The stimulus holds reset for three edges and always drives all inputs with known values. It takes most snapshots straight from the block's own lookup outputs, and deliberately injects arbitrary in-range snapshot indices to exercise training at indices unrelated to the current histories.

// File: rtl/tp_pkg.sv
`timescale 1ns/1ps
package tp_pkg;

   // One saturating step of a counter of up to 8 bits with ceiling maxv.
   function automatic logic [7:0] sat_next(input logic [7:0] cur,
                                           input logic       up,
                                           input logic [7:0] maxv);
      if (up)
         return (cur == maxv) ? cur : cur + 8'd1;
      else
         return (cur == 8'd0) ? cur : cur - 8'd1;
   endfunction

endpackage

// File: rtl/tp_sat_table.sv
`timescale 1ns/1ps
module tp_sat_table
   import tp_pkg::*;
#(
   parameter int IDX_W = 8,
   parameter int CNT_W = 2,
   parameter int INIT  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [CNT_W-1:0] rd_cnt,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_up,
   output logic [CNT_W-1:0] wr_cur
);
   localparam int DEPTH = 1 << IDX_W;
   localparam logic [CNT_W-1:0] CMAX  = '1;
   localparam logic [CNT_W-1:0] CINIT = CNT_W'(INIT);
   localparam logic [CNT_W-1:0] CONE  = CNT_W'(1);

   generate
      if (CNT_W < 1 || CNT_W > 8) begin : g_bad_width
         $error("tp_sat_table: CNT_W must lie in 1..8");
      end
      if (INIT < 0 || INIT >= (1 << CNT_W)) begin : g_bad_init
         $error("tp_sat_table: INIT out of counter range");
      end
   endgenerate

   logic [CNT_W-1:0] mem [DEPTH];
   logic [CNT_W-1:0] wr_nxt;

   always_comb begin
      wr_cur = mem[wr_idx];
      wr_nxt = CNT_W'(sat_next(8'(wr_cur), wr_up, 8'(CMAX)));
      rd_cnt = (wr_en && rd_idx == wr_idx) ? wr_nxt : mem[rd_idx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= CINIT;
      end else if (wr_en) begin
         mem[wr_idx] <= wr_nxt;
      end
   end

   // R3 / R4: counters stick at their ceiling and floor.
   a_r3_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && wr_en && wr_up && wr_cur == CMAX) |=> mem[$past(wr_idx)] == CMAX);
   a_r4_sat_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && wr_en && !wr_up && wr_cur == '0) |=> mem[$past(wr_idx)] == '0);
   // R3 / R4: away from the limits a training step moves exactly one.
   a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && wr_en && ((wr_up && wr_cur != CMAX) || (!wr_up && wr_cur != '0)))
      |=> mem[$past(wr_idx)] ==
          ($past(wr_up) ? $past(wr_cur) + CONE : $past(wr_cur) - CONE));
   // R8: an entry without a write keeps its value.
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !wr_en) |=> mem[$past(wr_idx)] == $past(wr_cur));

endmodule

// File: rtl/tp_hist_table.sv
`timescale 1ns/1ps
module tp_hist_table #(
   parameter int IDX_W = 6,
   parameter int H_W   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [H_W-1:0]   rd_hist,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_bit
);
   localparam int DEPTH = 1 << IDX_W;

   generate
      if (H_W < 2) begin : g_bad_hist
         $error("tp_hist_table: H_W must be at least 2");
      end
   endgenerate

   logic [H_W-1:0] mem [DEPTH];
   logic [H_W-1:0] cur, nxt;

   always_comb begin
      cur     = mem[wr_idx];
      nxt     = {cur[H_W-2:0], wr_bit};
      rd_hist = (wr_en && rd_idx == wr_idx) ? nxt : mem[rd_idx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[wr_idx] <= nxt;
      end
   end

   // R6: the written entry carries the new outcome in bit 0 after the edge.
   a_r6_newest_lsb: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && wr_en) |=> mem[$past(wr_idx)][0] == $past(wr_bit));
   // R6: older outcomes move up one place.
   a_r6_age_up: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && wr_en) |=> mem[$past(wr_idx)][H_W-1:1] == $past(cur[H_W-2:0]));

endmodule

// File: rtl/tournament_predictor.sv
`timescale 1ns/1ps
module tournament_predictor #(
   parameter int PC_W     = 16,
   parameter int GH_W     = 8,
   parameter int CH_IDX_W = 8,
   parameter int LH_IDX_W = 6,
   parameter int LP_W     = 6,
   parameter int LC_W     = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lk_pc,
   output logic            lk_taken,
   output logic            lk_use_global,
   output logic            lk_glob_taken,
   output logic            lk_loc_taken,
   output logic [GH_W-1:0] lk_ghist,
   output logic [LP_W-1:0] lk_lhist,
   input  logic            up_valid,
   input  logic [PC_W-1:0] up_pc,
   input  logic            up_taken,
   input  logic [GH_W-1:0] up_ghist,
   input  logic [LP_W-1:0] up_lhist
);
   localparam int TWO_W   = 2;
   localparam int LC_INIT = (1 << (LC_W - 1)) - 1;

   generate
      if (PC_W < CH_IDX_W || PC_W < LH_IDX_W) begin : g_bad_pc
         $error("tournament_predictor: PC_W narrower than an index");
      end
      if (GH_W < 2 || LP_W < 2) begin : g_bad_hist
         $error("tournament_predictor: histories need at least 2 bits");
      end
      if (LC_W < 2 || LC_W > 8) begin : g_bad_lc
         $error("tournament_predictor: LC_W must lie in 2..8");
      end
   endgenerate

   // Global history with same-cycle forwarding of an update.
   logic [GH_W-1:0] ghist_q, ghist_eff;
   always_comb ghist_eff = up_valid ? {ghist_q[GH_W-2:0], up_taken} : ghist_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        ghist_q <= '0;
      else if (up_valid) ghist_q <= ghist_eff;
   end

   // Local history table.
   logic [LP_W-1:0] lhist_rd;
   tp_hist_table #(.IDX_W(LH_IDX_W), .H_W(LP_W)) u_lhist (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (lk_pc[LH_IDX_W-1:0]),
      .rd_hist (lhist_rd),
      .wr_en   (up_valid),
      .wr_idx  (up_pc[LH_IDX_W-1:0]),
      .wr_bit  (up_taken)
   );

   // Counter tables.
   logic [TWO_W-1:0] g_rd, g_cur, ch_rd, ch_cur;
   logic [LC_W-1:0]  l_rd, l_cur;
   logic             g_ok, l_ok, ch_wr;

   tp_sat_table #(.IDX_W(GH_W), .CNT_W(TWO_W), .INIT(1)) u_gctr (
      .clk (clk), .rst_n (rst_n),
      .rd_idx (ghist_eff), .rd_cnt (g_rd),
      .wr_en (up_valid), .wr_idx (up_ghist), .wr_up (up_taken), .wr_cur (g_cur)
   );

   tp_sat_table #(.IDX_W(LP_W), .CNT_W(LC_W), .INIT(LC_INIT)) u_lctr (
      .clk (clk), .rst_n (rst_n),
      .rd_idx (lhist_rd), .rd_cnt (l_rd),
      .wr_en (up_valid), .wr_idx (up_lhist), .wr_up (up_taken), .wr_cur (l_cur)
   );

   always_comb begin
      g_ok  = (g_cur[TWO_W-1] == up_taken);
      l_ok  = (l_cur[LC_W-1]  == up_taken);
      ch_wr = up_valid && (g_ok != l_ok);
   end

   tp_sat_table #(.IDX_W(CH_IDX_W), .CNT_W(TWO_W), .INIT(1)) u_chooser (
      .clk (clk), .rst_n (rst_n),
      .rd_idx (lk_pc[CH_IDX_W-1:0]), .rd_cnt (ch_rd),
      .wr_en (ch_wr), .wr_idx (up_pc[CH_IDX_W-1:0]), .wr_up (g_ok), .wr_cur (ch_cur)
   );

   always_comb begin
      lk_glob_taken = g_rd[TWO_W-1];
      lk_loc_taken  = l_rd[LC_W-1];
      lk_use_global = ch_rd[TWO_W-1];
      lk_taken      = lk_use_global ? lk_glob_taken : lk_loc_taken;
      lk_ghist      = ghist_eff;
      lk_lhist      = lhist_rd;
   end

   logic unused_pc_bits;
   assign unused_pc_bits = ^{lk_pc, up_pc};

   // R5: history shifts on update, newest outcome in bit 0.
   a_r5_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && up_valid) |=> ghist_q == {$past(ghist_q[GH_W-2:0]), $past(up_taken)});
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && !up_valid) |=> $stable(ghist_q));
   // R9: a lookup alongside an update reports the already shifted history.
   a_r9_ghist_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid |-> (lk_ghist[0] == up_taken && lk_ghist[GH_W-1:1] == ghist_q[GH_W-2:0]));
   // R9: selector training is visible to a same-index lookup in that cycle.
   a_r9_sel_to_global: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_wr && g_ok && ch_cur != 2'd0 &&
       lk_pc[CH_IDX_W-1:0] == up_pc[CH_IDX_W-1:0]) |-> lk_use_global);
   a_r9_sel_to_local: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_wr && l_ok && ch_cur != 2'd3 &&
       lk_pc[CH_IDX_W-1:0] == up_pc[CH_IDX_W-1:0]) |-> !lk_use_global);

endmodule

// File: tb/tb_tournament_predictor.sv
`timescale 1ns/1ps
module tb_tournament_predictor;
   localparam int PC_W = 16, GH_W = 8, CH_IDX_W = 8, LH_IDX_W = 6, LP_W = 6, LC_W = 3;
   localparam int GMAX = 3, LMAX = (1 << LC_W) - 1;

   logic            clk = 1'b0, rst_n = 1'b0;
   logic [PC_W-1:0] lk_pc = '0, up_pc = '0;
   logic            up_valid = 1'b0, up_taken = 1'b0;
   logic [GH_W-1:0] up_ghist = '0;
   logic [LP_W-1:0] up_lhist = '0;
   logic            lk_taken, lk_use_global, lk_glob_taken, lk_loc_taken;
   logic [GH_W-1:0] lk_ghist;
   logic [LP_W-1:0] lk_lhist;

   always #2.5 clk = ~clk;

   tournament_predictor #(.PC_W(PC_W), .GH_W(GH_W), .CH_IDX_W(CH_IDX_W),
      .LH_IDX_W(LH_IDX_W), .LP_W(LP_W), .LC_W(LC_W)) dut (
      .clk, .rst_n, .lk_pc, .lk_taken, .lk_use_global, .lk_glob_taken,
      .lk_loc_taken, .lk_ghist, .lk_lhist, .up_valid, .up_pc, .up_taken,
      .up_ghist, .up_lhist);

   int checks = 0, errors = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // Reference model built from the requirements.
   int m_g  [1 << GH_W];
   int m_ch [1 << CH_IDX_W];
   int m_lh [1 << LH_IDX_W];
   int m_lc [1 << LP_W];
   int m_gh;

   function automatic int sat(input int v, input bit up, input int mx);
      if (up) return (v == mx) ? v : v + 1;
      return (v == 0) ? v : v - 1;
   endfunction

   task automatic model_reset();
      foreach (m_g[i])  m_g[i]  = 1;
      foreach (m_ch[i]) m_ch[i] = 1;
      foreach (m_lh[i]) m_lh[i] = 0;
      foreach (m_lc[i]) m_lc[i] = (1 << (LC_W - 1)) - 1;
      m_gh = 0;
   endtask

   task automatic model_update(input int pc, input bit t, input int gh, input int lh);
      bit gok, lok;
      int ci, li;
      gok = ((m_g[gh] >> 1) & 1) == t;               // R7
      lok = ((m_lc[lh] >> (LC_W - 1)) & 1) == t;
      m_g[gh]  = sat(m_g[gh], t, GMAX);              // R3
      m_lc[lh] = sat(m_lc[lh], t, LMAX);             // R4
      ci = pc % (1 << CH_IDX_W);
      if (gok != lok) m_ch[ci] = sat(m_ch[ci], gok, GMAX);  // R8
      li = pc % (1 << LH_IDX_W);
      m_lh[li] = ((m_lh[li] << 1) | t) % (1 << LP_W);        // R6
      m_gh = ((m_gh << 1) | t) % (1 << GH_W);                // R5
   endtask

   typedef struct {
      bit taken, use_g, g, l;
      int gh, lh;
   } exp_t;

   exp_t q[$];
   event mon_ev;

   // Driver: drive one cycle, push the expected lookup result.
   task automatic cyc(input int lpc, input bit upv, input int upc, input bit upt,
                      input int ugh, input int ulh, output exp_t e);
      int lhv;
      @(negedge clk);
      lk_pc    = PC_W'(lpc);
      up_valid = upv;
      up_pc    = PC_W'(upc);
      up_taken = upt;
      up_ghist = GH_W'(ugh);
      up_lhist = LP_W'(ulh);
      if (upv) model_update(upc, upt, ugh, ulh);     // R9: update first
      lhv     = m_lh[lpc % (1 << LH_IDX_W)];
      e.gh    = m_gh;
      e.lh    = lhv;
      e.g     = (m_g[m_gh] >> 1) & 1;
      e.l     = (m_lc[lhv] >> (LC_W - 1)) & 1;
      e.use_g = m_ch[lpc % (1 << CH_IDX_W)] >= 2;
      e.taken = e.use_g ? e.g : e.l;
      q.push_back(e);
      #1 ->mon_ev;
      @(posedge clk);
   endtask

   // Monitor: compare the design's lookup outputs against the queue.
   initial begin
      forever begin
         @(mon_ev);
         if (q.size() != 0) begin
            exp_t e;
            e = q.pop_front();
            chk(lk_taken == e.taken, "R2 final", int'(lk_taken), int'(e.taken));
            chk(lk_use_global == e.use_g, "R8 selector", int'(lk_use_global), int'(e.use_g));
            chk(lk_glob_taken == e.g, "R3 global", int'(lk_glob_taken), int'(e.g));
            chk(lk_loc_taken == e.l, "R4 local", int'(lk_loc_taken), int'(e.l));
            chk(int'(lk_ghist) == e.gh, "R5 R10 ghist", int'(lk_ghist), e.gh);
            chk(int'(lk_lhist) == e.lh, "R6 R10 lhist", int'(lk_lhist), e.lh);
         end
      end
   end

   // Lookup, then resolve one cycle later with the lookup's own snapshot.
   task automatic run(input int pc, input bit t);
      exp_t e, e2;
      cyc(pc, 0, 0, 0, 0, 0, e);
      cyc(pc, 1, pc, t, e.gh, e.lh, e2);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      exp_t e;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state seen at the ports.
      lk_pc = 16'h0123;
      #1;
      chk(lk_taken == 1'b0, "R1 taken", int'(lk_taken), 0);
      chk(lk_use_global == 1'b0, "R1 selector", int'(lk_use_global), 0);
      chk(lk_ghist == '0, "R1 ghist", int'(lk_ghist), 0);
      chk(lk_lhist == '0, "R1 lhist", int'(lk_lhist), 0);
      cyc(16'h0123, 0, 0, 0, 0, 0, e);

      // Loop-closing branch: nine taken then one exit, repeated.
      for (int it = 0; it < 30; it++)
         for (int k = 0; k < 10; k++) run(16'h0040, k != 9);

      // R3 R4: drive counters into both saturation limits.
      for (int k = 0; k < 12; k++) run(16'h0013, 1'b1);
      for (int k = 0; k < 12; k++) run(16'h0013, 1'b0);

      // R9: lookup and update share the PC in the same cycle.
      cyc(16'h0055, 1, 16'h0055, 1'b1, m_gh, m_lh[16'h0055 % 64], e);
      chk(lk_lhist[0] == 1'b1, "R9 forwarded local bit", int'(lk_lhist[0]), 1);
      cyc(16'h0055, 1, 16'h0055, 1'b0, m_gh, m_lh[16'h0055 % 64], e);
      chk(lk_ghist[0] == 1'b0, "R9 forwarded global bit", int'(lk_ghist[0]), 0);

      // R6: PCs aliasing in the low bits share one local entry.
      for (int k = 0; k < 20; k++) run((k % 2) ? 16'h0107 : 16'h0207, k % 3 == 0);

      // R7: updates with arbitrary snapshot indices unrelated to the histories.
      for (int k = 0; k < 300; k++)
         cyc($urandom % 65536, 1, $urandom % 65536, $urandom % 2,
             $urandom % 256, $urandom % 64, e);

      // Mixed traffic among a few branches with correlated outcomes.
      for (int k = 0; k < 600; k++) begin
         int pc;
         pc = 16'h1000 + 4 * ($urandom % 8);
         run(pc, ((m_gh & 3) == 1) ^ ($urandom % 8 == 0));
      end

      // R8: idle cycles leave everything unchanged.
      for (int k = 0; k < 5; k++) cyc(16'h0040, 0, 0, 0, 0, 0, e);

      @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule